// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. It runs on the serial bit clock and samples the frame clock and the data line on each rising edge. A two-bit format select chooses one of four framings: 16-bit right-aligned, 24-bit right-aligned, 24-bit left-aligned, or the common I2S layout with a one-bit delay and a word length of 16 or 24 bits. Every format sends data MSB first in two's complement.

Captured words appear on 24-bit left and right outputs. A 16-bit word sits in the upper bits, and its eight low bits are zero. A one-cycle strobe marks each completed left/right pair. In the right-aligned formats every incoming bit is shifted in, and the low 16 or 24 bits are taken at the frame-clock transition, so the half-frame length need not be known in advance. In the I2S format the word length is set by the measured half-frame length. The block changes format at run time from the select pins alone.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, both sample outputs are zero and the pair strobe is low until the first pair is captured.
- R2: With format select 2'b00, the left and right outputs carry the last 16 bits sent before the frame-clock transition that ends each half-frame. The word is placed in bits [23:8] and bits [7:0] are zero. This holds for half-frames of 16 and 32 bit clocks.
- R3: With format select 2'b01, each output carries the last 24 bits sent before the transition that ends its half-frame. Bits sent earlier in a longer half-frame (32 bit clocks) do not affect the result.
- R4: With format select 2'b10, each output carries the 24 bits sent on the first 24 rising edges of the half-frame, starting on the edge where the frame-clock change is first seen. Bits after the 24th do not affect the result.
- R5: With format select 2'b11, the word MSB arrives one rising edge after the frame-clock change. The word is 16 bits, placed in [23:8] with zero low bits, when the half-frame is 16 bit clocks or shorter, and 24 bits otherwise.
- R6: In formats 2'b00, 2'b01 and 2'b10, a half-frame with the frame clock high is the left channel. In format 2'b11, a half-frame with the frame clock low is the left channel. Each output changes only in the cycle after a frame-clock transition.
- R7: The pair strobe is high for exactly one cycle after each right-channel capture that follows a left-channel capture. It rises once per frame and only in the cycle after a frame-clock transition.
- R8: The first frame-clock transition after reset starts no capture. A right word captured with no preceding left word produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all logic uses its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Frame clock marking the channel half-frames |
| sdata | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing select (00, 01, 10, 11 as in R2 to R5) |
| left_o | output | 24 | Last captured left sample |
| right_o | output | 24 | Last captured right sample |
| pair_valid_o | output | 1 | One-cycle strobe after a complete left/right pair |

## Verification
The assertions assume that the frame clock stays at each level for at least two bit clocks. Without that, a one-cycle strobe followed by a quiet cycle could not be told apart from back-to-back captures. They also assume that the format select is held steady within a frame. The bench changes the format only while reset is asserted. Every half-frame it drives is 16, 24 or 32 bits long. Frame clock and data change on the falling edge, so the sampled values are stable at every rising edge.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int OUT_W    = 24;
    localparam int NARROW_W = 16;
    localparam int CNT_W    = 7;

    typedef enum logic [1:0] {
        FMT_RJ16 = 2'b00,
        FMT_RJ24 = 2'b01,
        FMT_LJ24 = 2'b10,
        FMT_I2S  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [OUT_W-1:0] left;
        logic [OUT_W-1:0] right;
        logic [OUT_W-1:0] shreg;
        logic             have_left;
        logic             valid;
    } core_st_t;

    function automatic logic [OUT_W-1:0] widen(input logic [NARROW_W-1:0] n);
        return {n, {(OUT_W-NARROW_W){1'b0}}};
    endfunction
endpackage

// File: rtl/sar_frame_tracker.sv
module sar_frame_tracker #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lr_i,
    output logic             edge_o,
    output logic             lr_prev_o,
    output logic             primed_o,
    output logic [CNT_W-1:0] pos_o,
    output logic [CNT_W-1:0] half_len_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             lr;
        logic             primed;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        next_cnt   = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
        edge_o     = lr_i ^ st_q.lr;
        pos_o      = edge_o ? '0 : next_cnt;
        half_len_o = next_cnt;
        lr_prev_o  = st_q.lr;
        primed_o   = st_q.primed;
        st_d        = st_q;
        st_d.lr     = lr_i;
        st_d.primed = st_q.primed | edge_o;
        st_d.cnt    = pos_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (pos_o == CNT_W'(1) || edge_o)); // R4
endmodule

// File: rtl/sar_msb_window.sv
module sar_msb_window #(
    parameter int OUT_W = 24,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_i,
    input  logic [CNT_W-1:0] pos_i,
    output logic [OUT_W-1:0] acc_o
);
    logic [OUT_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (pos_i < CNT_W'(OUT_W)) acc_d = {acc_q[OUT_W-2:0], sd_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i >= CNT_W'(OUT_W)) |=> $stable(acc_o)); // R4
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
(
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             frame_clk,
    input  logic             sdata,
    input  logic [1:0]       fmt_sel,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             pair_valid_o
);
    logic             fr_edge, lr_prev, primed;
    logic [CNT_W-1:0] pos, half_len;
    logic [OUT_W-1:0] acc;

    sar_frame_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk(bit_clk), .rst_n(rst_n), .lr_i(frame_clk),
        .edge_o(fr_edge), .lr_prev_o(lr_prev), .primed_o(primed),
        .pos_o(pos), .half_len_o(half_len)
    );

    sar_msb_window #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_win (
        .clk(bit_clk), .rst_n(rst_n), .sd_i(sdata), .pos_i(pos), .acc_o(acc)
    );

    core_st_t         st_d, st_q;
    fmt_e             fmt;
    logic [OUT_W-1:0] shifted, word;
    logic             take_left;

    always_comb begin
        fmt     = fmt_e'(fmt_sel);
        shifted = {st_q.shreg[OUT_W-2:0], sdata};
        case (fmt)
            FMT_RJ16: word = widen(st_q.shreg[NARROW_W-1:0]);
            FMT_RJ24: word = st_q.shreg;
            FMT_LJ24: word = acc;
            default:  word = (half_len <= CNT_W'(NARROW_W)) ?
                             widen(shifted[NARROW_W-1:0]) : shifted;
        endcase
        take_left = (fmt == FMT_I2S) ? !lr_prev : lr_prev;

        st_d       = st_q;
        st_d.shreg = shifted;
        st_d.valid = 1'b0;
        if (fr_edge && primed) begin
            if (take_left) begin
                st_d.left      = word;
                st_d.have_left = 1'b1;
            end else begin
                st_d.right     = word;
                st_d.valid     = st_q.have_left;
                st_d.have_left = 1'b0;
            end
        end
    end

    always_ff @(posedge bit_clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o       = st_q.left;
    assign right_o      = st_q.right;
    assign pair_valid_o = st_q.valid;

    AST_STROBE_SINGLE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o); // R7
    AST_STROBE_AFTER_EDGE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pair_valid_o |-> $past(fr_edge)); // R7
    AST_LEFT_AT_EDGE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !$stable(left_o) |-> $past(fr_edge)); // R6
    AST_RIGHT_AT_EDGE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !$stable(right_o) |-> $past(fr_edge)); // R6
    AST_NO_CAPTURE_UNPRIMED: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (fr_edge && !primed) |=> ($stable(left_o) && $stable(right_o) && !pair_valid_o)); // R8
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
    logic        bit_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_clk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [23:0] left_o, right_o;
    logic        pair_valid_o;

    always #2.5 bit_clk = ~bit_clk;

    serial_audio_rx i_serial_audio_rx (
        .bit_clk(bit_clk), .rst_n(rst_n), .frame_clk(frame_clk), .sdata(sdata),
        .fmt_sel(fmt_sel), .left_o(left_o), .right_o(right_o),
        .pair_valid_o(pair_valid_o)
    );

    int checks = 0;
    int fails  = 0;
    int ncap   = 0;
    int runs   = 0;
    logic        prev_valid = 1'b0;
    logic        last_lsb = 1'b0;
    logic [23:0] cap_l [0:31];
    logic [23:0] cap_r [0:31];
    logic [23:0] exp_l [0:31];
    logic [23:0] exp_r [0:31];

    always @(negedge bit_clk) begin
        if (pair_valid_o) begin
            if (ncap < 32) begin
                cap_l[ncap] = left_o;
                cap_r[ncap] = right_o;
            end
            ncap++;
            if (prev_valid) runs++;
        end
        prev_valid = pair_valid_o;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] f);
        @(negedge bit_clk);
        rst_n = 1'b0; frame_clk = 1'b0; sdata = 1'b0; fmt_sel = f;
        repeat (3) @(negedge bit_clk);
        rst_n = 1'b1;
    endtask

    task automatic send_half(input logic level, input logic [1:0] f,
                             input int len, input int w, input logic [23:0] d);
        for (int i = 0; i < len; i++) begin
            logic b;
            logic junk;
            junk = ~i[0];
            case (f)
                2'b00, 2'b01: b = (i >= len - w) ? d[len-1-i] : junk;
                2'b10:        b = (i < w) ? d[w-1-i] : junk;
                default:      b = (i == 0) ? last_lsb : ((i < w) ? d[w-i] : junk);
            endcase
            frame_clk = level;
            sdata = b;
            @(negedge bit_clk);
        end
        last_lsb = d[0];
    endtask

    task automatic send_frame(input logic [1:0] f, input int len, input int w,
                              input logic [23:0] l, input logic [23:0] r);
        logic lvl;
        lvl = (f == 2'b11) ? 1'b0 : 1'b1;
        send_half(lvl, f, len, w, l);
        send_half(~lvl, f, len, w, r);
    endtask

    task automatic run_case(input string req, input logic [1:0] f,
                            input int len, input int n);
        int w;
        int off;
        logic [23:0] mask;
        w    = (f == 2'b00 || (f == 2'b11 && len <= 16)) ? 16 : 24;
        mask = (w == 16) ? 24'h00FFFF : 24'hFFFFFF;
        off  = (f == 2'b11) ? 0 : 1;
        do_reset(f);
        ncap = 0; runs = 0; last_lsb = 1'b0;
        send_frame(f, len, w, 24'h123456 & mask, 24'h654321 & mask);
        for (int k = 0; k < n; k++) begin
            logic [23:0] lv, rv;
            if (k == 0) begin
                lv = (w == 16) ? 24'h008000 : 24'h800000;
                rv = (w == 16) ? 24'h007FFF : 24'h7FFFFF;
            end else begin
                lv = 24'((k * 32'h9E3779) ^ (len * 32'h1F2D3)) & mask;
                rv = (lv ^ 24'h5A5A5A) & mask;
            end
            exp_l[k] = (w == 16) ? {lv[15:0], 8'h00} : lv;
            exp_r[k] = (w == 16) ? {rv[15:0], 8'h00} : rv;
            send_frame(f, len, w, lv, rv);
        end
        send_frame(f, len, w, 24'h0F0F0F & mask, 24'h00FF00 & mask);
        repeat (4) @(negedge bit_clk);
        check("R8", $sformatf("%s len%0d pair count", req, len), ncap, n + off);
        check("R7", $sformatf("%s len%0d back-to-back strobes", req, len), runs, 0);
        for (int k = 0; k < n; k++) begin
            if (k + off < 32) begin
                check(req, $sformatf("len%0d left[%0d] R6", len, k), cap_l[k+off], exp_l[k]);
                check(req, $sformatf("len%0d right[%0d] R6", len, k), cap_r[k+off], exp_r[k]);
            end
        end
    endtask

    task automatic test_reset;
        do_reset(2'b00);
        check("R1", "left after reset", left_o, 0);
        check("R1", "right after reset", right_o, 0);
        check("R1", "strobe after reset", pair_valid_o, 0);
    endtask

    task automatic test_unprimed;
        // R8: I2S begins with the frame clock low, so the first transition falls mid-frame
        do_reset(2'b11);
        ncap = 0;
        send_half(1'b0, 2'b11, 24, 24, 24'hAAAAAA);
        send_half(1'b1, 2'b11, 24, 24, 24'h555555);
        send_half(1'b0, 2'b11, 4, 24, 24'h0);
        repeat (2) @(negedge bit_clk);
        check("R8", "no strobe from first partial frame", ncap, 0);
        check("R8", "left untouched after lone right", left_o, 0);
    endtask

    initial begin
        test_reset();
        run_case("R2", 2'b00, 16, 4);
        run_case("R2", 2'b00, 32, 4);
        run_case("R3", 2'b01, 24, 4);
        run_case("R3", 2'b01, 32, 4);
        run_case("R4", 2'b10, 24, 4);
        run_case("R4", 2'b10, 32, 4);
        run_case("R5", 2'b11, 24, 4);
        run_case("R5", 2'b11, 16, 4);
        test_unprimed();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule